// File: doc/BRIEF.md
# Network adapter control and interrupt register

This block is the single byte-wide control and status register of a small Ethernet adapter. The host sets it up over a simple CPU bus with an address, a write data byte, a read data byte and one-cycle read and write strobes. The register holds an interrupt enable for each direction and a sticky flag for each direction. The receive flag records that a good frame arrived, and the transmit flag records that a frame finished sending. The register also shows which of the two receive buffers the adapter filled last. The host uses it to choose which receive buffer is mapped into the read window, and to hold the PHY in reset.

The receive engine gives a one-cycle good-frame pulse together with the index of the buffer it just filled. The transmit engine gives a one-cycle done pulse. A single level interrupt goes high when an enabled event flag is set. A write to the register clears both event flags, and with them the interrupt, whatever byte is written. Host code normally reads the register and writes the same value back to acknowledge. If an engine pulse lands in the same cycle as a write, the event is kept, so no frame goes unannounced.

Top module: `netif_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00, and `irq`, `phy_reset` and `rx_win_sel` are all low.
- R2: A write to the register address stores data bits 7 (receive interrupt enable), 6 (transmit interrupt enable), 1 (read-window buffer select) and 0 (PHY reset hold). From the next cycle they read back at those positions, and bits 1 and 0 drive `rx_win_sel` and `phy_reset`.
- R3: A pulse on `rx_frame_ok` sets bit 5 from the next cycle, and bit 5 stays set until a write clears it.
- R4: A pulse on `tx_frame_done` sets bit 4 from the next cycle, and bit 4 stays set until a write clears it.
- R5: A pulse on `rx_frame_ok` loads `rx_buf_id` into bit 2. Bit 2 keeps that value through any writes until the next receive pulse.
- R6: Any write to the register clears bits 5 and 4 unless an event arrives in the same cycle. Writing ones to bits 5 and 4 never sets them.
- R7: `irq` is high exactly when (bit 7 and bit 5) or (bit 6 and bit 4).
- R8: When an event pulse coincides with a write, the flag for that event is set after the write.
- R9: Bit 3 always reads 0, and writes to bits 3 and 2 have no effect.
- R10: Writes to any other address change nothing. `bus_rdata` is 0x00 unless `bus_rd` is high with the register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data, combinational during a read |
| rx_frame_ok | input | 1 | One-cycle pulse: a good frame was stored |
| rx_buf_id | input | 1 | Buffer index that goes with `rx_frame_ok` |
| tx_frame_done | input | 1 | One-cycle pulse: a frame finished sending |
| irq | output | 1 | Level interrupt request |
| phy_reset | output | 1 | Holds the PHY in reset when high |
| rx_win_sel | output | 1 | Receive buffer mapped into the read window |

## Verification
The embedded properties run on every cycle. They check that an event pulse sets its flag on the following cycle even when a write lands in the same cycle. They check that a write with no event leaves both flags and the interrupt low, and that the last-buffer bit holds steady whenever no receive pulse occurs. They also check that the read bus is quiet outside a read of the register address. Other behaviour only shows up over a sequence of bus accesses, so the directed scenarios cover it. These include writes that try to set the read-only and unused bits, interrupt masking with an enable cleared and then set while a flag is pending, the last-buffer bit surviving an acknowledge write, and accesses to a foreign address.

// File: rtl/netif_ctl_pkg.sv
package netif_ctl_pkg;

    localparam int REG_W = 8;

    // Bit positions of the control/status byte; host code decodes them.
    localparam int B_RX_IE   = 7;
    localparam int B_TX_IE   = 6;
    localparam int B_RX_SEEN = 5;
    localparam int B_TX_SEEN = 4;
    localparam int B_LAST_RX = 2;
    localparam int B_WIN_SEL = 1;
    localparam int B_PHY_RST = 0;

    // Event kinds, used to index the sticky flag array.
    localparam int N_EVT  = 2;
    localparam int EVT_RX = 0;
    localparam int EVT_TX = 1;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic rx_seen;
        logic tx_seen;
        logic rsvd;
        logic last_rx;
        logic win_sel;
        logic phy_hold;
    } ctl_byte_t;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic win_sel;
        logic phy_hold;
    } host_ctl_t;

    function automatic host_ctl_t take_host_bits(input logic [REG_W-1:0] d);
        host_ctl_t h;
        h.rx_ie    = d[B_RX_IE];
        h.tx_ie    = d[B_TX_IE];
        h.win_sel  = d[B_WIN_SEL];
        h.phy_hold = d[B_PHY_RST];
        return h;
    endfunction

    function automatic logic irq_level(input host_ctl_t h,
                                       input logic [N_EVT-1:0] seen);
        return (h.rx_ie & seen[EVT_RX]) | (h.tx_ie & seen[EVT_TX]);
    endfunction

endpackage

// File: rtl/netif_ctl_decode.sv
module netif_ctl_decode #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h41
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    logic match;

    always_comb begin
        match    = (addr_i == REG_ADDR);
        rd_hit_o = rd_i & match;
        wr_hit_o = wr_i & match;
    end
endmodule

// File: rtl/netif_ctl_flag.sv
module netif_ctl_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);                                   // R8
    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);                      // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);                      // R3
endmodule

// File: rtl/netif_ctl_hostbits.sv
module netif_ctl_hostbits
    import netif_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             rx_ok_i,
    input  logic             rx_buf_i,
    output host_ctl_t        ctl_o,
    output logic             last_rx_o
);
    always_ff @(posedge clk) begin
        if (rst)       ctl_o <= '0;
        else if (wr_i) ctl_o <= take_host_bits(wdata_i);
    end

    always_ff @(posedge clk) begin
        if (rst)          last_rx_o <= 1'b0;
        else if (rx_ok_i) last_rx_o <= rx_buf_i;
    end

    AST_PHY_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ctl_o.phy_hold == $past(wdata_i[B_PHY_RST]));  // R2
    AST_LAST_BUF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rx_ok_i |=> $stable(last_rx_o));                      // R5
    AST_LAST_BUF_LOADS: assert property (@(posedge clk) disable iff (rst)
        rx_ok_i |=> last_rx_o == $past(rx_buf_i));             // R5
endmodule

// File: rtl/netif_ctl_reg.sv
module netif_ctl_reg
    import netif_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h41
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic              rx_frame_ok,
    input  logic              rx_buf_id,
    input  logic              tx_frame_done,
    output logic              irq,
    output logic              phy_reset,
    output logic              rx_win_sel
);
    logic             rd_hit, wr_hit, last_rx;
    host_ctl_t        hctl;
    logic [N_EVT-1:0] evt_in, seen;
    ctl_byte_t        view;

    netif_ctl_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr),
        .rd_hit_o(rd_hit), .wr_hit_o(wr_hit)
    );

    netif_ctl_hostbits u_host (
        .clk(clk), .rst(rst), .wr_i(wr_hit), .wdata_i(bus_wdata),
        .rx_ok_i(rx_frame_ok), .rx_buf_i(rx_buf_id),
        .ctl_o(hctl), .last_rx_o(last_rx)
    );

    assign evt_in[EVT_RX] = rx_frame_ok;
    assign evt_in[EVT_TX] = tx_frame_done;

    for (genvar e = 0; e < N_EVT; e++) begin : g_flag
        netif_ctl_flag u_flag (
            .clk(clk), .rst(rst), .set_i(evt_in[e]), .clr_i(wr_hit),
            .flag_o(seen[e])
        );
    end

    always_comb begin
        view          = '0;
        view.rx_ie    = hctl.rx_ie;
        view.tx_ie    = hctl.tx_ie;
        view.rx_seen  = seen[EVT_RX];
        view.tx_seen  = seen[EVT_TX];
        view.last_rx  = last_rx;
        view.win_sel  = hctl.win_sel;
        view.phy_hold = hctl.phy_hold;
        bus_rdata     = rd_hit ? view : '0;
    end

    assign irq        = irq_level(hctl, seen);
    assign phy_reset  = hctl.phy_hold;
    assign rx_win_sel = hctl.win_sel;

    // Write data bits that have no storage behind them.
    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[5:2]};

    AST_RX_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rx_frame_ok && !wr_hit && hctl.rx_ie) |=> irq);                 // R7
    AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !rx_frame_ok && !tx_frame_done) |=> !irq);            // R6
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == REG_ADDR) |-> bus_rdata == 8'h00);       // R10
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != REG_ADDR && !rx_frame_ok && !tx_frame_done)
        |=> $stable(irq) && $stable(phy_reset) && $stable(rx_win_sel));  // R10
endmodule

// File: tb/netif_ctl_reg_bench.sv
module netif_ctl_reg_bench;
    localparam logic [7:0] RA = 8'h41;
    localparam logic [7:0] OTHER = 8'h43;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_rd, bus_wr, rx_frame_ok, rx_buf_id, tx_frame_done;
    logic       irq, phy_reset, rx_win_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    netif_ctl_reg u_netif_ctl_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .rx_frame_ok(rx_frame_ok), .rx_buf_id(rx_buf_id),
        .tx_frame_done(tx_frame_done), .irq(irq),
        .phy_reset(phy_reset), .rx_win_sel(rx_win_sel)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One bus cycle with optional events, applied between two falling edges.
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic rx, input logic rb, input logic tx);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        rx_frame_ok = rx; rx_buf_id = rb; tx_frame_done = tx;
        @(negedge clk);
        bus_wr = 0; rx_frame_ok = 0; tx_frame_done = 0; bus_addr = 8'h00;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        bus_rd = 0; bus_addr = 8'h00;
        #1;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] exp, input logic exp_irq);
        logic [7:0] v;
        read_at(RA, v);
        check(req, v, exp);
        check({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
    endtask

    task automatic t_reset;
        expect_reg("R1", 8'h00, 1'b0);
        check("R1 phy", {7'b0, phy_reset}, 8'h00);
        check("R1 sel", {7'b0, rx_win_sel}, 8'h00);
    endtask

    task automatic t_host_bits;
        cycle(1, RA, 8'hC3, 0, 0, 0);
        expect_reg("R2", 8'hC3, 1'b0);
        check("R2 phy", {7'b0, phy_reset}, 8'h01);
        check("R2 sel", {7'b0, rx_win_sel}, 8'h01);
        cycle(1, RA, 8'h3C, 0, 0, 0);          // tries bits 5..2 only
        expect_reg("R9 R6", 8'h00, 1'b0);
        check("R2 phy off", {7'b0, phy_reset}, 8'h00);
    endtask

    task automatic t_rx_event;
        cycle(1, RA, 8'h80, 0, 0, 0);
        cycle(0, RA, 8'h00, 1, 1, 0);
        expect_reg("R3 R5 R7", 8'hA4, 1'b1);
        cycle(1, RA, 8'hA4, 0, 0, 0);          // acknowledge
        expect_reg("R6 R5", 8'h84, 1'b0);
    endtask

    task automatic t_tx_event;
        cycle(1, RA, 8'h00, 0, 0, 0);
        cycle(0, RA, 8'h00, 0, 0, 1);
        expect_reg("R4 R7 masked", 8'h14, 1'b0);
        cycle(1, RA, 8'h40, 0, 0, 0);
        expect_reg("R6", 8'h44, 1'b0);
        cycle(0, RA, 8'h00, 0, 0, 1);
        expect_reg("R4 R7", 8'h54, 1'b1);
        cycle(1, RA, 8'h00, 0, 0, 0);
        expect_reg("R7 cleared", 8'h04, 1'b0);
    endtask

    task automatic t_collision;
        cycle(1, RA, 8'hC0, 0, 0, 0);
        cycle(1, RA, 8'hC0, 1, 0, 0);
        expect_reg("R8 rx", 8'hE0, 1'b1);
        cycle(1, RA, 8'hC0, 0, 0, 1);
        expect_reg("R8 tx", 8'hD0, 1'b1);
    endtask

    task automatic t_foreign;
        logic [7:0] v;
        cycle(1, OTHER, 8'hFF, 0, 0, 0);
        expect_reg("R10 write", 8'hD0, 1'b1);
        read_at(OTHER, v);
        check("R10 read other", v, 8'h00);
        #1 check("R10 idle", bus_rdata, 8'h00);
        cycle(0, RA, 8'h00, 1, 1, 0);
        expect_reg("R5 buf1", 8'hF4, 1'b1);
        cycle(0, RA, 8'h00, 1, 0, 0);
        expect_reg("R5 buf0", 8'hF0, 1'b1);
    endtask

    initial begin
        bus_addr = 0; bus_wdata = 0; bus_rd = 0; bus_wr = 0;
        rx_frame_ok = 0; rx_buf_id = 0; tx_frame_done = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_host_bits();
        t_rx_event();
        t_tx_event();
        t_collision();
        t_foreign();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule